// File: doc/BRIEF.md
# Real-Mode Effective Address Generator

This block turns an already decoded memory operand into a 20-bit physical address. It takes an addressing-mode code, the values of up to two address registers with codes saying which registers they are, a signed 16-bit displacement, a scale code, an optional segment override and the four segment register values. It returns the segment that was used, the 16-bit effective offset and the physical address.

Results are registered. They appear one clock after a single-cycle request strobe. The segment is either picked by a default rule or forced by the override input. The default rule gives the stack segment whenever BP is the first (base) register, and the data segment otherwise. A request with an unsupported mode, or with an invalid register pairing, raises an error pulse and leaves the previous results in place.

Register codes are BX=0, BP=1, SI=2, DI=3. Segment identifiers are ES=0, CS=1, SS=2, DS=3.

Mode codes:

| Code | Mode | Offset formed as |
|------|------|------------------|
| 0 | direct | displacement |
| 1 | register indirect | first register |
| 2 | base plus index | first + second |
| 3 | register relative | first + displacement |
| 4 | base relative plus index | first + second + displacement |
| 5 | scaled index | first + (second × scale) + displacement |
| 6, 7 | illegal | — |

Top module: `ea_gen`

## Requirements
- R1: For every accepted request, `paddr` equals the chosen segment value times 16 plus `offset`, truncated to 20 bits, so a sum past FFFFFh wraps to the bottom of the space.
- R2: Mode 1 (register indirect) uses `first_val` alone as the offset. It accepts any of the four register codes (BX=0, BP=1, SI=2, DI=3). The segment is SS (2) when the first code is BP, and DS (3) otherwise.
- R3: Mode 2 (base plus index) requires a first code of BX or BP and a second code of SI or DI. The offset is `first_val + second_val`, and BP as the base selects SS.
- R4: In modes 3 (register relative) and 4 (base relative plus index), `disp` is a two's-complement value added to the register sum, so a negative displacement subtracts. Mode 4 carries the same register-pair rule as mode 2.
- R5: Mode 5 (scaled index) multiplies only `second_val`, by 1, 2, 4 or 8 for `scale` codes 0, 1, 2 and 3, then adds `first_val` and `disp`. In every other mode, `scale` has no effect.
- R6: Mode 0 (direct) uses `disp` as the offset and selects DS (3) unless an override is given.
- R7: When `ovr_en` is high, `ovr_seg` replaces the default segment in every mode.
- R8: All offset arithmetic wraps modulo 2^16 before the segment is added.
- R9: A request with mode code 6 or 7, or with a mode 2 or 4 register pairing that breaks the base/index rule, gives a one-cycle `err` pulse one cycle later. `valid` stays low, and `seg_id`, `offset` and `paddr` keep their previous values.
- R10: After reset, `valid`, `err`, `seg_id`, `offset` and `paddr` are all zero. A legal request raises `valid` for exactly the one following cycle, and no output event occurs without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one cycle per operand |
| mode | input | 3 | Addressing-mode code |
| first_reg | input | 2 | Code of the first (base) register |
| second_reg | input | 2 | Code of the second (index) register |
| first_val | input | 16 | Value of the first register |
| second_val | input | 16 | Value of the second register |
| disp | input | 16 | Signed displacement, or the direct address |
| scale | input | 2 | Scale code applied to the second register in mode 5 |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Overriding segment identifier |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| valid | output | 1 | Result valid, one cycle after a legal request |
| err | output | 1 | Illegal request pulse |
| seg_id | output | 2 | Segment used |
| offset | output | 16 | Effective offset |
| paddr | output | 20 | Physical address |

## Verification
Each mode is driven with distinct register values so that a wrong operand selection shows up in the offset. Each mode is also driven with BX and BP alternately in the base position, which separates the SS default from the DS default. Negative displacements, and a sum that passes FFFFh, catch arithmetic that fails to wrap at 16 bits. A segment of FFFFh catches a 20-bit sum that fails to wrap. Scale codes 0, 2 and 3 in mode 5, with a nonzero scale code left in mode 2, show that the scale reaches only the second register and only in its own mode. Illegal modes and a swapped base/index pairing are each followed by a check that the earlier result is still held.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int OFS_W = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [2:0]       mode,
  input  logic [1:0]       first_reg,
  input  logic [1:0]       second_reg,
  input  logic [OFS_W-1:0] first_val,
  input  logic [OFS_W-1:0] second_val,
  input  logic [OFS_W-1:0] disp,
  input  logic [1:0]       scale,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_seg,
  input  logic [OFS_W-1:0] seg_es,
  input  logic [OFS_W-1:0] seg_cs,
  input  logic [OFS_W-1:0] seg_ss,
  input  logic [OFS_W-1:0] seg_ds,
  output logic             valid,
  output logic             err,
  output logic [1:0]       seg_id,
  output logic [OFS_W-1:0] offset,
  output logic [OFS_W+SEG_SHIFT-1:0] paddr
);
  localparam int PA_W = OFS_W + SEG_SHIFT;
  localparam logic [1:0] REG_BP = 2'd1;
  localparam logic [1:0] SEG_SS = 2'd2;
  localparam logic [1:0] SEG_DS = 2'd3;

  logic             use_first, use_second, use_disp, paired, illegal;
  logic [OFS_W-1:0] second_scaled, sum;
  logic [1:0]       seg_pick;
  logic [OFS_W-1:0] seg_val;
  logic [PA_W-1:0]  phys;

  assign use_first  = (mode != 3'd0);
  assign use_second = (mode == 3'd2) || (mode == 3'd4) || (mode == 3'd5);
  assign use_disp   = (mode == 3'd0) || (mode == 3'd3) || (mode == 3'd4) || (mode == 3'd5);
  assign paired     = (mode == 3'd2) || (mode == 3'd4);
  assign illegal    = (mode > 3'd5) || (paired && (first_reg[1] || !second_reg[1]));

  assign second_scaled = (mode == 3'd5) ? OFS_W'(second_val << scale) : second_val;

  assign sum = (use_first  ? first_val     : '0)
             + (use_second ? second_scaled : '0)
             + (use_disp   ? disp          : '0);

  assign seg_pick = ovr_en ? ovr_seg
                  : (use_first && first_reg == REG_BP) ? SEG_SS : SEG_DS;

  always_comb begin
    case (seg_pick)
      2'd0:    seg_val = seg_es;
      2'd1:    seg_val = seg_cs;
      2'd2:    seg_val = seg_ss;
      default: seg_val = seg_ds;
    endcase
  end

  assign phys = {seg_val, {SEG_SHIFT{1'b0}}} + PA_W'(sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      err    <= 1'b0;
      seg_id <= '0;
      offset <= '0;
      paddr  <= '0;
    end else begin
      valid <= req && !illegal;
      err   <= req && illegal;
      if (req && !illegal) begin
        seg_id <= seg_pick;
        offset <= sum;
        paddr  <= phys;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic [2:0]  mode,
  input logic [15:0] disp,
  input logic        ovr_en,
  input logic [1:0]  ovr_seg,
  input logic [15:0] seg_es,
  input logic [15:0] seg_cs,
  input logic [15:0] seg_ss,
  input logic [15:0] seg_ds,
  input logic        valid,
  input logic        err,
  input logic [1:0]  seg_id,
  input logic [15:0] offset,
  input logic [19:0] paddr
);
  logic [15:0] es_q, cs_q, ss_q, ds_q, used_seg;

  always_ff @(posedge clk) begin
    es_q <= seg_es;
    cs_q <= seg_cs;
    ss_q <= seg_ss;
    ds_q <= seg_ds;
  end

  always_comb begin
    case (seg_id)
      2'd0:    used_seg = es_q;
      2'd1:    used_seg = cs_q;
      2'd2:    used_seg = ss_q;
      default: used_seg = ds_q;
    endcase
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(req)); // R10
  AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req)); // R9
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && err)); // R9
  AST_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(offset) && $stable(paddr) && $stable(seg_id))); // R9
  AST_PHYS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> paddr == ({used_seg, 4'b0000} + {4'b0000, offset})); // R1
  AST_DIRECT_DS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(mode) == 3'd0 && !$past(ovr_en)) |-> (seg_id == 2'd3 && offset == $past(disp))); // R6
  AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(ovr_en)) |-> seg_id == $past(ovr_seg)); // R7
endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .disp(disp),
  .ovr_en(ovr_en), .ovr_seg(ovr_seg),
  .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
  .valid(valid), .err(err), .seg_id(seg_id), .offset(offset), .paddr(paddr)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  first_reg = '0, second_reg = '0, scale = '0, ovr_seg = '0;
  logic [15:0] first_val = '0, second_val = '0, disp = '0;
  logic        ovr_en = 1'b0;
  logic [15:0] seg_es = 16'h3000, seg_cs = 16'h4000, seg_ss = 16'h2000, seg_ds = 16'h0100;
  logic        valid, err;
  logic [1:0]  seg_id;
  logic [15:0] offset;
  logic [19:0] paddr;

  int checks = 0, errors = 0;

  typedef struct {
    logic        e;
    logic [1:0]  seg;
    logic [15:0] off;
    logic [19:0] pa;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [1:0]  last_seg = '0;
  logic [15:0] last_off = '0;
  logic [19:0] last_pa  = '0;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .first_reg(first_reg), .second_reg(second_reg),
    .first_val(first_val), .second_val(second_val), .disp(disp), .scale(scale),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .valid(valid), .err(err), .seg_id(seg_id), .offset(offset), .paddr(paddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] seg_value(input logic [1:0] s);
    case (s)
      2'd0:    return seg_es;
      2'd1:    return seg_cs;
      2'd2:    return seg_ss;
      default: return seg_ds;
    endcase
  endfunction

  task automatic go(input string tag, input logic [2:0] m,
                    input logic [1:0] fr, input logic [1:0] sr,
                    input logic [15:0] fv, input logic [15:0] sv,
                    input logic [15:0] d, input logic [1:0] sc,
                    input logic oe, input logic [1:0] os);
    exp_t x;
    logic bad;
    logic [15:0] s2, o;
    logic [1:0] sg;
    @(negedge clk);
    mode = m; first_reg = fr; second_reg = sr; first_val = fv; second_val = sv;
    disp = d; scale = sc; ovr_en = oe; ovr_seg = os; req = 1'b1;
    bad = (m > 3'd5) || ((m == 3'd2 || m == 3'd4) && (fr >= 2'd2 || sr < 2'd2));
    x.tag = tag;
    if (bad) begin
      x.e = 1'b1; x.seg = last_seg; x.off = last_off; x.pa = last_pa;
    end else begin
      s2 = (m == 3'd5) ? 16'(sv * (16'd1 << sc)) : sv;
      case (m)
        3'd0:    o = d;
        3'd1:    o = fv;
        3'd2:    o = fv + s2;
        3'd3:    o = fv + d;
        default: o = fv + s2 + d;
      endcase
      sg = oe ? os : ((m != 3'd0 && fr == 2'd1) ? 2'd2 : 2'd3);
      x.e = 1'b0; x.seg = sg; x.off = o;
      x.pa = 20'((seg_value(sg) * 20'd16) + o);
      last_seg = sg; last_off = o; last_pa = x.pa;
    end
    q.push_back(x);
    @(negedge clk);
    req = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && (valid || err)) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 output event without request: valid=%0b err=%0b expected none", valid, err);
      end else begin
        exp_t x;
        x = q.pop_front();
        checks++;
        if (err !== x.e || valid !== !x.e || seg_id !== x.seg || offset !== x.off || paddr !== x.pa) begin
          errors++;
          $display("FAIL %s: err=%0b valid=%0b seg=%0d off=%h pa=%h expected err=%0b seg=%0d off=%h pa=%h",
                   x.tag, err, valid, seg_id, offset, paddr, x.e, x.seg, x.off, x.pa);
        end
      end
    end
  end

  task automatic summary;
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 missing results: %0d outstanding expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired: run hung, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (valid !== 1'b0 || err !== 1'b0 || seg_id !== 2'd0 || offset !== 16'h0 || paddr !== 20'h0) begin
      errors++;
      $display("FAIL R10 reset state: valid=%0b err=%0b seg=%0d off=%h pa=%h expected all zero",
               valid, err, seg_id, offset, paddr);
    end
    // codes: BX=0 BP=1 SI=2 DI=3 ; segments ES=0 CS=1 SS=2 DS=3
    go("R6 direct",              3'd0, 2'd0, 2'd2, 16'h5555, 16'h6666, 16'h1234, 2'd0, 1'b0, 2'd0);
    go("R2 indirect BX",         3'd1, 2'd0, 2'd2, 16'h1000, 16'h7777, 16'h0444, 2'd0, 1'b0, 2'd0);
    go("R2 indirect BP",         3'd1, 2'd1, 2'd2, 16'h0040, 16'h7777, 16'h0444, 2'd0, 1'b0, 2'd0);
    go("R2 indirect DI",         3'd1, 2'd3, 2'd2, 16'h0ABC, 16'h7777, 16'h0444, 2'd0, 1'b0, 2'd0);
    go("R3 BX+DI",               3'd2, 2'd0, 2'd3, 16'h0200, 16'h0030, 16'h0999, 2'd0, 1'b0, 2'd0);
    go("R3 BP+SI",               3'd2, 2'd1, 2'd2, 16'h0100, 16'h0011, 16'h0999, 2'd0, 1'b0, 2'd0);
    go("R5 scale ignored mode2", 3'd2, 2'd0, 2'd2, 16'h0100, 16'h0010, 16'h0000, 2'd3, 1'b0, 2'd0);
    go("R4 BX minus 4",          3'd3, 2'd0, 2'd2, 16'h0300, 16'h0000, 16'hFFFC, 2'd0, 1'b0, 2'd0);
    go("R4 BP+DI minus 10h",     3'd4, 2'd1, 2'd3, 16'h0500, 16'h0020, 16'hFFF0, 2'd0, 1'b0, 2'd0);
    go("R5 scale x4",            3'd5, 2'd0, 2'd2, 16'h1000, 16'h0003, 16'h0000, 2'd2, 1'b0, 2'd0);
    go("R5 scale x1",            3'd5, 2'd2, 2'd0, 16'h1000, 16'h0003, 16'h0002, 2'd0, 1'b0, 2'd0);
    go("R5 scale x8 BP",         3'd5, 2'd1, 2'd3, 16'h0010, 16'h0101, 16'h0000, 2'd3, 1'b0, 2'd0);
    go("R7 override ES on BP",   3'd1, 2'd1, 2'd2, 16'h0040, 16'h0000, 16'h0000, 2'd0, 1'b1, 2'd0);
    go("R7 override CS direct",  3'd0, 2'd0, 2'd2, 16'h0000, 16'h0000, 16'h0008, 2'd0, 1'b1, 2'd1);
    go("R8 offset wrap",         3'd2, 2'd0, 2'd2, 16'hFFFF, 16'h0002, 16'h0000, 2'd0, 1'b0, 2'd0);
    go("R9 illegal mode 6",      3'd6, 2'd0, 2'd2, 16'h1111, 16'h2222, 16'h3333, 2'd0, 1'b0, 2'd0);
    go("R9 illegal SI as base",  3'd4, 2'd2, 2'd3, 16'h1111, 16'h2222, 16'h3333, 2'd0, 1'b0, 2'd0);
    go("R9 illegal mode 7",      3'd7, 2'd0, 2'd2, 16'h1111, 16'h2222, 16'h3333, 2'd0, 1'b0, 2'd0);
    @(negedge clk);
    seg_ds = 16'hFFFF;
    go("R1 physical wrap",       3'd0, 2'd0, 2'd2, 16'h0000, 16'h0000, 16'h0020, 2'd0, 1'b0, 2'd0);
    go("R1 physical plain",      3'd3, 2'd0, 2'd2, 16'h0001, 16'h0000, 16'h0001, 2'd0, 1'b0, 2'd0);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule